// File: doc/BRIEF.md
# Latchable Registered Bus Transceiver Path

This block carries one direction of a two-group bus transceiver. An 18-bit input port is split into two 9-bit groups, each made of eight data bits and one parity bit. Each group has its own storage element. The element has three behaviours. With the latch enable high it is a transparent latch. With the latch enable low it is an edge register: it loads when the bus clock rises and that group's clock enable is asserted. Otherwise it holds its value. An active-low output enable decides whether the stored value is driven onto the far port.

Everything runs on one system clock. The transparent latch is modelled by sampling the port on every system clock edge while the latch enable is high. The bus clock is treated as a data input and its rising edge is detected against the system clock. The floating port is not modelled with a tri-state driver. Instead it is represented by a registered drive flag placed beside the data. The parity bits are stored and passed along like the other bits; this block does not compute or check them.

Top module: `xcvr_path_ab`

## Requirements
- R1: While `latch_en` is 1, every group's `b_data` bits equal the `a_port` value sampled at the previous system clock edge.
- R2: When `latch_en` is 0 and a bus clock rising edge is detected (`bus_clk` is 1 at a system clock edge and was 0 at the edge before it), each group whose `clk_en_n` bit is 0 loads `a_port` at that edge.
- R3: When `latch_en` is 0 and there is no detected rising edge, `b_data` stays unchanged, whatever `a_port` does.
- R4: `clk_en_n[g]` equal to 1 blocks loading for group g only. The other group still loads on the same edge.
- R5: After `latch_en` falls, each group keeps the value taken at the last edge where `latch_en` was 1, until that group sees a qualifying rising edge.
- R6: A bus clock that stays high loads only once. A rising edge that occurs while `latch_en` is 1 does not cause a load after `latch_en` falls.
- R7: `b_drive` equals the inverse of `oe_n` sampled at the previous edge. `oe_n` has no effect on `b_data`.
- R8: Group 0 occupies bits 8:0 and group 1 occupies bits 17:9. Bit 8 is group 0's parity bit and bit 17 is group 1's parity bit. Parity bits are stored exactly like data bits.
- R9: Synchronous active-high `rst` clears `b_data` to 0 and `b_drive` to 0. If `bus_clk` is already high when reset is released, that is not a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk | input | 1 | Bus clock, edge-detected against `clk` |
| latch_en | input | 1 | 1 = transparent, 0 = edge register |
| clk_en_n | input | 2 | Per-group load enable, active low |
| oe_n | input | 1 | Output enable, active low |
| a_port | input | 18 | Input port, two 9-bit groups |
| b_data | output | 18 | Stored value presented to the far port |
| b_drive | output | 1 | 1 = far port driven, 0 = floating |

## Verification
The assertions assume that `bus_clk`, `latch_en`, `clk_en_n`, `oe_n` and `a_port` are already synchronous to `clk`. Under that assumption, a value seen at one edge is the value that was held throughout the preceding cycle. The bench meets this assumption by changing every input just after a rising edge of `clk`. It also holds each bus clock level for at least one full system cycle, so the edge detector always sees each low and each high phase.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned GROUPS = 2;

    typedef enum logic [1:0] {
        LOAD_HOLD    = 2'd0,
        LOAD_FOLLOW  = 2'd1,
        LOAD_CAPTURE = 2'd2
    } load_mode_e;
endpackage

// File: rtl/xcvr_clk_edge.sv
module xcvr_clk_edge (
    input  logic clk,
    input  logic rst,
    input  logic bus_clk,
    output logic rise
);
    typedef struct packed {
        logic seen_hi;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.seen_hi = bus_clk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.seen_hi <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = bus_clk & ~st_q.seen_hi;

    a_r6_edge_once: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
    a_r6_needs_low: assert property (@(posedge clk) disable iff (rst)
        rise |-> !$past(bus_clk));
endmodule

// File: rtl/xcvr_group_store.sv
module xcvr_group_store #(
    parameter int unsigned GW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          latch_en,
    input  logic          rise,
    input  logic          ld_en_n,
    input  logic [GW-1:0] din,
    output logic [GW-1:0] dout
);
    import xcvr_pkg::*;

    typedef struct packed {
        logic [GW-1:0] val;
    } grp_st_t;

    grp_st_t    st_d, st_q;
    load_mode_e mode;

    always_comb begin
        if (latch_en) begin
            mode = LOAD_FOLLOW;
        end else if (rise && !ld_en_n) begin
            mode = LOAD_CAPTURE;
        end else begin
            mode = LOAD_HOLD;
        end
        st_d = st_q;
        case (mode)
            LOAD_FOLLOW:  st_d.val = din;
            LOAD_CAPTURE: st_d.val = din;
            default:      st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.val;

    a_r1_follow: assert property (@(posedge clk) disable iff (rst)
        latch_en |=> (dout == $past(din)));
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && rise && !ld_en_n) |=> (dout == $past(din)));
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !rise) |=> $stable(dout));
    a_r4_blocked: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && ld_en_n) |=> $stable(dout));
endmodule

// File: rtl/xcvr_drive_reg.sv
module xcvr_drive_reg (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    output logic drive
);
    typedef struct packed {
        logic on;
    } drv_st_t;

    drv_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.on = ~oe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.on <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive = st_q.on;

    a_r7_on: assert property (@(posedge clk) disable iff (rst)
        !oe_n |=> drive);
    a_r7_off: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> !drive);
endmodule

// File: rtl/xcvr_path_ab.sv
module xcvr_path_ab #(
    parameter int unsigned DATA_W = xcvr_pkg::DATA_W,
    parameter int unsigned GROUPS = xcvr_pkg::GROUPS,
    localparam int unsigned GW    = DATA_W + 1,
    localparam int unsigned TW    = GW * GROUPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk,
    input  logic              latch_en,
    input  logic [GROUPS-1:0] clk_en_n,
    input  logic              oe_n,
    input  logic [TW-1:0]     a_port,
    output logic [TW-1:0]     b_data,
    output logic              b_drive
);
    logic rise;

    xcvr_clk_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .bus_clk (bus_clk),
        .rise    (rise)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        xcvr_group_store #(.GW(GW)) u_store (
            .clk      (clk),
            .rst      (rst),
            .latch_en (latch_en),
            .rise     (rise),
            .ld_en_n  (clk_en_n[g]),
            .din      (a_port[g*GW +: GW]),
            .dout     (b_data[g*GW +: GW])
        );
    end

    xcvr_drive_reg u_drv (
        .clk   (clk),
        .rst   (rst),
        .oe_n  (oe_n),
        .drive (b_drive)
    );

    a_r7_data_indep: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !rise) |=> $stable(b_data));
endmodule

// File: tb/sim_xcvr_path_ab.sv
module sim_xcvr_path_ab;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_clk;
    logic        latch_en;
    logic [1:0]  clk_en_n;
    logic        oe_n;
    logic [17:0] a_port;
    logic [17:0] b_data;
    logic        b_drive;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    xcvr_path_ab u0 (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .latch_en(latch_en),
        .clk_en_n(clk_en_n), .oe_n(oe_n), .a_port(a_port),
        .b_data(b_data), .b_drive(b_drive)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; bus_clk = 1'b1; latch_en = 1'b0; clk_en_n = 2'b00;
        oe_n = 1'b0; a_port = 18'h2A5A5;
        step(); step();
        chk("R9 reset data", b_data, 18'h0);
        chk("R9 reset drive", {17'h0, b_drive}, 18'h0);
        rst = 1'b0; oe_n = 1'b1;
        step();
        chk("R9 high bus_clk at release is no edge", b_data, 18'h0);
    endtask

    task automatic t_follow();
        latch_en = 1'b1; a_port = 18'h15555;
        step();
        chk("R1 follow pattern 1", b_data, 18'h15555);
        a_port = 18'h20100;
        step();
        chk("R8 parity bits 8 and 17 stored", b_data, 18'h20100);
        a_port = 18'h3FFFF;
        step();
        chk("R1 follow all ones", b_data, 18'h3FFFF);
    endtask

    task automatic t_close();
        a_port = 18'h0A0F3;
        step();
        latch_en = 1'b0; a_port = 18'h11111;
        step();
        chk("R5 value held after close", b_data, 18'h0A0F3);
        a_port = 18'h2EEEE;
        step();
        chk("R3 input change ignored", b_data, 18'h0A0F3);
    endtask

    task automatic t_capture();
        bus_clk = 1'b0; clk_en_n = 2'b00;
        step();
        a_port = 18'h12345; bus_clk = 1'b1;
        step();
        chk("R2 capture on rise", b_data, 18'h12345);
        a_port = 18'h06789;
        step();
        chk("R6 high bus_clk no reload", b_data, 18'h12345);
        bus_clk = 1'b0;
        step();
        chk("R3 falling bus_clk holds", b_data, 18'h12345);
        bus_clk = 1'b1;
        step();
        chk("R2 second rise captures", b_data, 18'h06789);
    endtask

    task automatic t_group_en();
        bus_clk = 1'b0; clk_en_n = 2'b10;
        step();
        a_port = 18'h3FFFF; bus_clk = 1'b1;
        step();
        chk("R4 group0 loads group1 blocked", b_data, {9'h033, 9'h1FF});
        bus_clk = 1'b0; clk_en_n = 2'b01; a_port = 18'h00000;
        step();
        bus_clk = 1'b1;
        step();
        chk("R4 group1 loads group0 blocked", b_data, {9'h000, 9'h1FF});
        bus_clk = 1'b0; clk_en_n = 2'b11; a_port = 18'h2AAAA;
        step();
        bus_clk = 1'b1;
        step();
        chk("R4 both blocked", b_data, {9'h000, 9'h1FF});
    endtask

    task automatic t_rise_in_follow();
        bus_clk = 1'b0; clk_en_n = 2'b00; latch_en = 1'b1; a_port = 18'h13579;
        step();
        bus_clk = 1'b1;
        step();
        latch_en = 1'b0; a_port = 18'h02468;
        step();
        chk("R6 rise during follow not replayed", b_data, 18'h13579);
    endtask

    task automatic t_drive();
        logic [17:0] held;
        held = b_data;
        oe_n = 1'b0;
        step();
        chk("R7 drive on", {17'h0, b_drive}, 18'h1);
        chk("R7 data unaffected by enable", b_data, held);
        oe_n = 1'b1;
        step();
        chk("R7 drive off", {17'h0, b_drive}, 18'h0);
        chk("R7 data unaffected by disable", b_data, held);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_follow();
        t_close();
        t_capture();
        t_group_en();
        t_rise_in_follow();
        t_drive();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule